// File: doc/BRIEF.md
# General-Purpose I/O Pin Bank

This block controls up to 32 general-purpose pins through a small word-wide register port. Software writes a drive value, a direction mask, a blink mask and an input-polarity mask, and reads back the sampled pin levels. A pin whose direction bit is 1 is an input and its driver is off. A pin whose direction bit is 0 drives its output value. When a driving pin also has its blink bit set, its drive value is gated by a slow square wave, so a pin set high flashes while a pin set low stays low. The input side passes every pin through a two-flop synchronizer and then XORs it with the polarity mask. The corrected level is shown in the read-only input register and is also brought out on its own port for an interrupt block to use.

The register port carries control traffic, so it is plain and has no valid/ready handshake. A write takes effect at the clock edge where `reg_we` is high. A read is combinational from `reg_addr` and has no back-pressure: `reg_rdata` is valid in the same cycle as the address. Addresses are byte addresses, and each register occupies one aligned 32-bit word.

Top module: `gpio_bank`

## Requirements
- R1: After reset every implemented pin is an input: the direction register reads all ones in its implemented bits and `pin_oe` is all zero. The drive, blink and polarity registers read zero, and `pin_out` is zero.
- R2: Writes to byte offset 0x00 (drive value), 0x04 (direction), 0x08 (blink mask) and 0x0C (input polarity) store the low NPINS bits of `reg_wdata`. A read at the same offset returns the stored value.
- R3: `pin_oe[i]` is 1 exactly when direction bit i is 0. A direction bit of 1 means input.
- R4: A pin whose blink bit is 0 has `pin_out[i]` equal to drive bit i.
- R5: A pin whose blink bit is 1 has `pin_out[i]` equal to drive bit i ANDed with a square wave. The wave is 0 at reset and inverts after every BLINK_HALF clock edges. A low drive bit keeps the pin low.
- R6: The input register at offset 0x10 and the `pin_level` port both equal the value `pin_in` had two clock edges earlier, XORed with the current polarity register.
- R7: Writes to offset 0x10, to unmapped offsets and to unaligned addresses change no register and no pin output.
- R8: Reads from unmapped or unaligned addresses return zero. Bits at NPINS and above always read zero.
- R9: Clearing a pin's blink bit returns `pin_out` for that pin to its plain drive value starting with the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Value driven onto each pin |
| pin_oe | output | NPINS | Driver enable per pin, 1 = drive |
| pin_level | output | NPINS | Synchronized, polarity-corrected input levels |

## Verification
The hardest behaviour to reach from the ports is the phase of the blink wave. It depends only on the number of clock edges since reset, and no register exposes it. The bench counts edges from reset release and computes the expected wave from that count. It then checks `pin_out` in every cycle across several blink periods, on pins that are driven high and on pins that are driven low. The two-cycle input latency is tested by holding the read address on the input register while `pin_in` changes, and checking the old value for two cycles before the new one. Writes to the read-only and unmapped offsets are each followed by a full readback, to show that they had no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Word indices of the register map; the byte offset is index * 4.
  localparam int IDX_OUT   = 0;
  localparam int IDX_DIR   = 1;
  localparam int IDX_BLINK = 2;
  localparam int IDX_POL   = 3;
  localparam int IDX_DIN   = 4;
  localparam int NUM_RW    = 4;
  localparam int MAX_PINS  = 32;
  localparam int DATA_W    = 32;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int HALF_PERIOD = 250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int CW = (HALF_PERIOD < 2) ? 1 : $clog2(HALF_PERIOD);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(HALF_PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      wave  <= ~wave;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NPINS-1:0]  din_val,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  blink_q,
  output logic [NPINS-1:0]  pol_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic              aligned;
  logic [IDX_W-1:0]  widx;
  logic [NUM_RW-1:0] wr_hit;
  logic [NPINS-1:0]  cfg_q [NUM_RW];
  logic [NPINS-1:0]  rd_pins;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign widx    = reg_addr[ADDR_W-1:2];

  for (genvar k = 0; k < NUM_RW; k++) begin : g_reg
    assign wr_hit[k] = reg_we && aligned && (widx == IDX_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[k] <= (k == IDX_DIR) ? '1 : '0;
      else if (wr_hit[k])
        cfg_q[k] <= reg_wdata[NPINS-1:0];
    end
  end

  assign out_q   = cfg_q[IDX_OUT];
  assign dir_q   = cfg_q[IDX_DIR];
  assign blink_q = cfg_q[IDX_BLINK];
  assign pol_q   = cfg_q[IDX_POL];

  always_comb begin
    rd_pins = '0;
    if (aligned) begin
      case (widx)
        IDX_W'(IDX_OUT):   rd_pins = out_q;
        IDX_W'(IDX_DIR):   rd_pins = dir_q;
        IDX_W'(IDX_BLINK): rd_pins = blink_q;
        IDX_W'(IDX_POL):   rd_pins = pol_q;
        IDX_W'(IDX_DIN):   rd_pins = din_val;
        default:           rd_pins = '0;
      endcase
    end
    reg_rdata = '0;
    reg_rdata[NPINS-1:0] = rd_pins;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int ADDR_W     = 8,
  parameter int BLINK_HALF = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_level
);
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] blink_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] sync_q;
  logic             wave;

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (sync_q)
  );

  gpio_blink_gen #(.HALF_PERIOD(BLINK_HALF)) u_blink (
    .clk  (clk),
    .rst_n(rst_n),
    .wave (wave)
  );

  gpio_ctrl_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .din_val  (pin_level),
    .reg_rdata(reg_rdata),
    .out_q    (out_q),
    .dir_q    (dir_q),
    .blink_q  (blink_q),
    .pol_q    (pol_q)
  );

  assign pin_level = sync_q ^ pol_q;
  assign pin_oe    = ~dir_q;
  // A blinking pin is forced low while the wave is low.
  assign pin_out   = out_q & ~(blink_q & {NPINS{~wave}});
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [NPINS-1:0]  pin_in,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  pin_level,
  input logic [NPINS-1:0]  pol_q
);
  localparam logic [31:0] IMPL = (NPINS >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NPINS) - 32'd1);

  logic [1:0] warm_cnt;
  logic       mapped;

  assign mapped = (reg_addr[1:0] == 2'b00) && (reg_addr[ADDR_W-1:2] <= (ADDR_W-2)'(4));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(4)) |=> (pin_oe == ~$past(reg_wdata[NPINS-1:0])));

  // R6
  input_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_cnt >= 2'd2) |-> (pin_level == ($past(pin_in, 2) ^ pol_q)));

  // R7
  din_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(16)) |=> $stable(pin_oe));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (reg_rdata == 32'd0));

  // R8
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~IMPL) == 32'd0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_we   (reg_we),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .pin_in   (pin_in),
  .pin_out  (pin_out),
  .pin_oe   (pin_oe),
  .pin_level(pin_level),
  .pol_q    (pol_q)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
module gpio_bank_bench;
  localparam int NP   = 24;
  localparam int AW   = 8;
  localparam int HALF = 5;
  localparam logic [31:0] M = 32'h00FF_FFFF;

  localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_BLK = 8'h08,
                         A_POL = 8'h0C, A_DIN = 8'h10;

  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_LVL = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pin_level;

  item_t q[$];
  int n_chk = 0, n_fail = 0, edges = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) edges++;

  gpio_bank #(.NPINS(NP), .ADDR_W(AW), .BLINK_HALF(HALF)) u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_level(pin_level)
  );

  // Monitor: compares every queued expectation at the falling edge.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_OUT:   act = 32'(pin_out);
        K_OE:    act = 32'(pin_oe);
        default: act = 32'(pin_level);
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    push(K_RD, exp, tag);
    tick();
  endtask

  function automatic logic [31:0] blink_exp(input logic [31:0] o, input logic [31:0] b);
    logic w;
    w = ((edges / HALF) % 2) == 1;
    return w ? (o & M) : (o & ~b & M);
  endfunction

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(A_OUT, 32'h0, "R1 drive reset");
    rd(A_DIR, M, "R1 direction reset");
    rd(A_BLK, 32'h0, "R1 blink reset");
    rd(A_POL, 32'h0, "R1 polarity reset");
    push(K_OE, 32'h0, "R1 oe reset");
    push(K_OUT, 32'h0, "R1 pin_out reset");
    tick();

    // R2 readback, R8 upper bits cleared
    wr(A_OUT, 32'hA5A5_A5A5);
    rd(A_OUT, 32'h00A5_A5A5, "R2 drive readback / R8 upper bits");
    wr(A_DIR, 32'hFFFF_0000);
    rd(A_DIR, 32'h00FF_0000, "R2 direction readback");
    // R3 direction to enable, R4 plain drive
    push(K_OE, 32'h0000_FFFF, "R3 oe from direction");
    push(K_OUT, 32'h00A5_A5A5, "R4 plain drive");
    tick();
    wr(A_POL, 32'h0000_FF00);
    rd(A_POL, 32'h0000_FF00, "R2 polarity readback");

    // R6 two-edge latency then polarity XOR
    reg_addr = A_DIN;
    pin_in = 24'h123456;
    rd(A_DIN, 32'h0000_FF00, "R6 old value edge 1");
    rd(A_DIN, 32'h0000_FF00, "R6 old value edge 2");
    rd(A_DIN, 32'h0012_CB56, "R6 new value");
    push(K_LVL, 32'h0012_CB56, "R6 pin_level");
    tick();
    wr(A_POL, 32'h0);
    rd(A_DIN, 32'h0012_3456, "R6 polarity cleared");

    // R7 ignored writes
    wr(A_DIN, 32'hFFFF_FFFF);
    wr(8'h14, 32'hDEAD_BEEF);
    wr(8'h01, 32'h0000_0000);
    wr(8'hFC, 32'h0000_0000);
    rd(A_OUT, 32'h00A5_A5A5, "R7 drive unchanged");
    rd(A_DIR, 32'h00FF_0000, "R7 direction unchanged");
    rd(A_BLK, 32'h0, "R7 blink unchanged");
    rd(A_POL, 32'h0, "R7 polarity unchanged");
    rd(A_DIN, 32'h0012_3456, "R7 input unchanged");
    push(K_OE, 32'h0000_FFFF, "R7 oe unchanged");
    push(K_OUT, 32'h00A5_A5A5, "R7 pin_out unchanged");
    tick();

    // R8 unmapped and unaligned reads
    rd(8'h14, 32'h0, "R8 offset 0x14");
    rd(8'h1C, 32'h0, "R8 offset 0x1C");
    rd(8'h03, 32'h0, "R8 unaligned");
    rd(8'hFC, 32'h0, "R8 top offset");

    // R5 blink: high pins flash, low pins stay low
    wr(A_OUT, 32'h0000_F0F0);
    wr(A_BLK, 32'h00FF_00F0);
    for (int i = 0; i < 4 * HALF + 3; i++) begin
      push(K_OUT, blink_exp(32'h0000_F0F0, 32'h00FF_00F0), "R5 blink wave");
      tick();
    end

    // R9 blink cleared returns to plain drive
    wr(A_BLK, 32'h0);
    for (int i = 0; i < 2 * HALF + 1; i++) begin
      push(K_OUT, 32'h0000_F0F0, "R9 blink cleared");
      tick();
    end

    @(negedge clk); #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule